// File: doc/BRIEF.md
# Triggered Look-Back Window Readout for Four Time-to-Digital Channels

The block records a per-clock history for four timing channels and, when a trigger arrives, reads back a window of that history as a compact stream of tagged hits. Every clock each channel delivers a fine-time code and a valid bit. Both are written into that channel's dual-page RAM at the low bits of a free-running coarse time counter. Words are written whether the hit is valid or not, so each page always holds the most recent 128 clocks of history.

An accepted trigger swaps the pages. The page that was just filled is frozen for reading, and recording continues in the other page without a gap. A sequencer then walks a window that starts a programmable number of clocks before the trigger and covers a programmable number of locations. At each location it loads all four channel words into a transfer register and shifts them out one per clock in channel order. Only valid entries are pushed to the output FIFO interface, each tagged with its channel number and absolute coarse time. A header word carrying the trigger's coarse time is pushed first. Every pushed word also carries the FIFO almost-full state.

Top module: `trig_window_readout`

## Requirements
- R1: The coarse time counter reads 0 in the first clock after reset, advances by one every clock, and wraps at 2^16. The header carries the counter value of the clock in which the trigger was high.
- R2: Every clock, each channel's valid bit and fine code are written at page address equal to coarse time bits [6:0]. This happens whether the hit is valid or not, and a readout returns exactly what was written for that coarse time.
- R3: An accepted trigger swaps the pages. The write made in the trigger clock still lands in the page being read out, and later writes go to the other page.
- R4: The header word is pushed in the clock after the trigger clock. Its layout is bit 25 = 1 (header kind), bit 24 = almost-full, bits [23:22] = 0, bits [21:6] = trigger coarse time, bits [5:0] = 0.
- R5: The window covers coarse times n−L1 through n−L1+L2−1, where n is the trigger coarse time, L1 = win_back (0 to 127) and L2 = win_len. A win_len of 0 or any value above 128 reads 128 locations. Data is only meaningful when L2 ≤ L1+1.
- R6: Hit words leave in location-major order with channels 0, 1, 2, 3 within a location. The word for window location s and channel k is pushed 4·s+k+3 clocks after the header.
- R7: A hit word is pushed only when its stored valid bit is 1. Its layout is bit 25 = 0, bit 24 = almost-full, bits [23:22] = channel, bits [21:6] = the hit's coarse time, bits [5:0] = fine code.
- R8: Bit 24 of every pushed word equals fifo_afull in the clock before the word appears on the output.
- R9: A trigger is ignored while a readout is in progress. This covers every clock from the header clock h through h+4·L2+1, and the trigger's window settings are not taken. A trigger in clock h+4·L2+2 or later is accepted.
- R10: During reset and until the first accepted trigger, out_push stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 4 | Per-channel hit valid bit for the current clock |
| hit_fine | input | 24 | Per-channel 6-bit fine code, channel k at bits [6k+5:6k] |
| trig | input | 1 | Trigger pulse |
| win_back | input | 7 | Look-back offset L1, sampled when a trigger is accepted |
| win_len | input | 8 | Window length L2, sampled when a trigger is accepted |
| fifo_afull | input | 1 | Almost-full state of the downstream FIFO |
| out_push | output | 1 | Push strobe toward the FIFO |
| out_data | output | 26 | Header or hit word |

## Verification
A new header and the last hits of the previous window can compete for the same output clock. The same is true of a page swap and the reads still being made from the frozen page. Both are provoked by retriggering at the last busy clock, h+4·L2+1, and again one clock later. The earlier trigger must leave no header and no swap. The later one must produce its header in the clock right after the final hit, and the second window must contain only data recorded after the first swap. Both windows are judged word by word on content and exact output clock, against a stream model computed from the requirements.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int unsigned NCH_DEF   = 4;
  localparam int unsigned FT_W_DEF  = 6;
  localparam int unsigned TC_W_DEF  = 16;
  localparam int unsigned PG_AW_DEF = 7;

  // Kind bit at the top of every output word
  typedef enum logic {
    KIND_HIT = 1'b0,
    KIND_HDR = 1'b1
  } kind_e;
endpackage

// File: rtl/twr_page_ram.sv
// Simple dual-port memory: one write and one registered read per clock.
module twr_page_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twr_sequencer.sv
// Trigger acceptance, page select, window counter and delayed tag copy.
module twr_sequencer #(
  parameter  int unsigned NCH   = 4,
  parameter  int unsigned PG_AW = 7,
  parameter  int unsigned TC_W  = 16,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned CNT_W = PG_AW + CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [PG_AW-1:0] win_back,
  input  logic [PG_AW:0]   win_len,
  input  logic [TC_W-1:0]  tc,
  output logic             accept,
  output logic             busy,
  output logic             wr_page,
  output logic [PG_AW:0]   rd_addr,
  output logic             load,
  output logic             mt_valid,
  output logic [CH_W-1:0]  mt_chan,
  output logic [TC_W-1:0]  mt_tc
);
  logic              active_q, act_d1_q, act_d2_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d1_q, cnt_d2_q;
  logic [PG_AW-1:0]  last_q;
  logic [TC_W-1:0]   mstart_q;
  logic              page_q;
  logic [PG_AW-1:0]  last_slot;
  logic              cnt_end;

  // Busy spans the counter plus the two-stage drain (RAM read, transfer reg)
  assign busy   = active_q | act_d1_q | act_d2_q;
  assign accept = trig & ~busy;

  // Lengths of 0 or above one page read a whole page
  assign last_slot = win_len[PG_AW] ? {PG_AW{1'b1}}
                                    : (win_len[PG_AW-1:0] - PG_AW'(1));
  assign cnt_end   = (cnt_q == {last_q, {CH_W{1'b1}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      mstart_q <= '0;
      page_q   <= 1'b0;
      act_d1_q <= 1'b0;
      act_d2_q <= 1'b0;
      cnt_d1_q <= '0;
      cnt_d2_q <= '0;
    end else begin
      if (accept) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        last_q   <= last_slot;
        mstart_q <= tc - TC_W'(win_back);
        page_q   <= ~page_q;
      end else if (active_q) begin
        if (cnt_end) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      act_d1_q <= active_q;
      act_d2_q <= act_d1_q;
      cnt_d1_q <= cnt_q;
      cnt_d2_q <= cnt_d1_q;
    end
  end

  assign wr_page  = page_q;
  assign rd_addr  = {~page_q, PG_AW'(mstart_q[PG_AW-1:0] + cnt_q[CNT_W-1:CH_W])};
  // Words for a slot are on the RAM outputs one clock after the address
  assign load     = act_d1_q & (cnt_d1_q[CH_W-1:0] == '0);
  // Tag copy lines up with the head of the transfer register
  assign mt_valid = act_d2_q;
  assign mt_chan  = cnt_d2_q[CH_W-1:0];
  assign mt_tc    = mstart_q + TC_W'(cnt_d2_q[CNT_W-1:CH_W]);
endmodule

// File: rtl/twr_merge.sv
// Parallel-load transfer register; entry 0 leaves first.
module twr_merge #(
  parameter  int unsigned NCH  = 4,
  parameter  int unsigned FT_W = 6,
  localparam int unsigned EW   = FT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NCH*EW-1:0] din,
  output logic             head_vld,
  output logic [FT_W-1:0]  head_ft
);
  logic [EW-1:0] sr [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_stage
    if (i == NCH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)       sr[i] <= '0;
        else if (load) sr[i] <= din[i*EW +: EW];
        else           sr[i] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)       sr[i] <= '0;
        else if (load) sr[i] <= din[i*EW +: EW];
        else           sr[i] <= sr[i+1];
      end
    end
  end

  assign head_vld = sr[0][EW-1];
  assign head_ft  = sr[0][FT_W-1:0];
endmodule

// File: rtl/trig_window_readout.sv
module trig_window_readout
  import twr_pkg::*;
#(
  parameter  int unsigned NCH    = NCH_DEF,
  parameter  int unsigned FT_W   = FT_W_DEF,
  parameter  int unsigned TC_W   = TC_W_DEF,
  parameter  int unsigned PG_AW  = PG_AW_DEF,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned EW     = FT_W + 1,
  localparam int unsigned WORD_W = 2 + CH_W + TC_W + FT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      hit_valid,
  input  logic [NCH*FT_W-1:0] hit_fine,
  input  logic                trig,
  input  logic [PG_AW-1:0]    win_back,
  input  logic [PG_AW:0]      win_len,
  input  logic                fifo_afull,
  output logic                out_push,
  output logic [WORD_W-1:0]   out_data
);
  logic [TC_W-1:0]   tc_q;
  logic              accept, seq_busy, wr_page, load;
  logic [PG_AW:0]    rd_addr;
  logic              mt_valid;
  logic [CH_W-1:0]   mt_chan;
  logic [TC_W-1:0]   mt_tc;
  logic [NCH*EW-1:0] rd_bus;
  logic              head_vld;
  logic [FT_W-1:0]   head_ft;
  logic              push_q;
  logic [WORD_W-1:0] data_q;

  // Free-running coarse time
  always_ff @(posedge clk) begin
    if (rst) tc_q <= '0;
    else     tc_q <= tc_q + TC_W'(1);
  end

  twr_sequencer #(.NCH(NCH), .PG_AW(PG_AW), .TC_W(TC_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .win_back (win_back),
    .win_len  (win_len),
    .tc       (tc_q),
    .accept   (accept),
    .busy     (seq_busy),
    .wr_page  (wr_page),
    .rd_addr  (rd_addr),
    .load     (load),
    .mt_valid (mt_valid),
    .mt_chan  (mt_chan),
    .mt_tc    (mt_tc)
  );

  // One history RAM per channel, written every clock
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    twr_page_ram #(.AW(PG_AW + 1), .DW(EW)) u_ram (
      .clk   (clk),
      .we    (1'b1),
      .waddr ({wr_page, tc_q[PG_AW-1:0]}),
      .wdata ({hit_valid[g], hit_fine[g*FT_W +: FT_W]}),
      .raddr (rd_addr),
      .rdata (rd_bus[g*EW +: EW])
    );
  end

  twr_merge #(.NCH(NCH), .FT_W(FT_W)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .din      (rd_bus),
    .head_vld (head_vld),
    .head_ft  (head_ft)
  );

  // Output word: header on accept, otherwise zero-suppressed hits
  always_ff @(posedge clk) begin
    if (rst) begin
      push_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      push_q <= 1'b1;
      data_q <= {1'(KIND_HDR), fifo_afull, {CH_W{1'b0}}, tc_q, {FT_W{1'b0}}};
    end else if (mt_valid && head_vld) begin
      push_q <= 1'b1;
      data_q <= {1'(KIND_HIT), fifo_afull, mt_chan, mt_tc, head_ft};
    end else begin
      push_q <= 1'b0;
    end
  end

  assign out_push = push_q;
  assign out_data = data_q;
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
  parameter int unsigned W    = 26,
  parameter int unsigned TC_W = 16,
  parameter int unsigned FT_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            trig,
  input logic            fifo_afull,
  input logic            out_push,
  input logic [W-1:0]    out_data,
  input logic            busy,
  input logic [TC_W-1:0] tc,
  input logic            wr_page
);
  a_r1_tc_reset: assert property (@(posedge clk) rst |=> tc == '0);

  a_r1_tc_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tc == $past(tc) + TC_W'(1));

  a_r4_header: assert property (@(posedge clk) disable iff (rst)
    (trig && !busy) |=> (out_push && out_data[W-1] &&
                         out_data[TC_W+FT_W-1:FT_W] == $past(tc)));

  a_r9_no_header_busy: assert property (@(posedge clk) disable iff (rst)
    (trig && busy) |=> !(out_push && out_data[W-1]));

  a_r9_page_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> wr_page == $past(wr_page));

  a_r8_afull_flag: assert property (@(posedge clk) disable iff (rst)
    out_push |-> out_data[W-2] == $past(fifo_afull));

  a_r7_hit_in_readout: assert property (@(posedge clk) disable iff (rst)
    (out_push && !out_data[W-1]) |-> $past(busy));
endmodule

bind trig_window_readout twr_checker #(.W(WORD_W), .TC_W(TC_W), .FT_W(FT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trig       (trig),
  .fifo_afull (fifo_afull),
  .out_push   (out_push),
  .out_data   (out_data),
  .busy       (seq_busy),
  .tc         (tc_q),
  .wr_page    (wr_page)
);

// File: tb/tb_trig_window_readout.sv
module tb_trig_window_readout;
  localparam int NCH = 4, FT_W = 6, TC_W = 16, PG_AW = 7, W = 26;
  localparam int CAP = 700, NV = 8;
  // {L1[7:0], L2[7:0], mode[1:0], afull}
  localparam logic [18:0] VEC [NV] = '{
    {8'd10,  8'd5,   2'd2, 1'b0},
    {8'd0,   8'd1,   2'd0, 1'b0},
    {8'd127, 8'd128, 2'd0, 1'b0},
    {8'd127, 8'd1,   2'd2, 1'b1},
    {8'd50,  8'd20,  2'd1, 1'b0},
    {8'd3,   8'd4,   2'd3, 1'b1},
    {8'd64,  8'd64,  2'd2, 1'b1},
    {8'd127, 8'd200, 2'd2, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, fifo_afull = 1'b0;
  logic [NCH-1:0]      hit_valid = '0;
  logic [NCH*FT_W-1:0] hit_fine = '0;
  logic [PG_AW-1:0]    win_back = '0;
  logic [PG_AW:0]      win_len = 8'd1;
  logic                out_push;
  logic [W-1:0]        out_data;

  int checks = 0, errors = 0, cyc = 0, tc_now = 0, mode = 0;
  int cap_n = 0, exp_n = 0;
  bit done = 1'b0;
  int         cap_cyc [CAP];
  logic [W-1:0] cap_dat [CAP];
  int         exp_cyc [CAP];
  logic [W-1:0] exp_dat [CAP];

  always #5 clk = ~clk;

  trig_window_readout dut (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_fine(hit_fine),
    .trig(trig), .win_back(win_back), .win_len(win_len),
    .fifo_afull(fifo_afull), .out_push(out_push), .out_data(out_data)
  );

  // Independent model of the coarse time (R1)
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    tc_now <= rst ? 0 : (tc_now + 1) % 65536;
  end

  function automatic bit hv(int t, int ch, int m);
    case (m)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return ((t * 7 + ch * 13) % 5) < 2;
      default: return ch == 3;
    endcase
  endfunction

  function automatic logic [FT_W-1:0] hf(int t, int ch);
    return FT_W'((t * 5 + ch * 11 + 3) % 64);
  endfunction

  // Drive hit inputs for the current coarse time and capture pushes
  always @(negedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      hit_valid[ch] = hv(tc_now, ch, mode);
      hit_fine[ch*FT_W +: FT_W] = hf(tc_now, ch);
    end
    if (out_push && cap_n < CAP) begin
      cap_cyc[cap_n] = cyc;
      cap_dat[cap_n] = out_data;
      cap_n++;
    end
  end

  task automatic chk(string tag, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic add_exp(int c, logic [W-1:0] d);
    if (exp_n < CAP) begin
      exp_cyc[exp_n] = c;
      exp_dat[exp_n] = d;
      exp_n++;
    end
  endtask

  // Expected stream per R4..R7
  task automatic add_window(int tcyc, int n, int l1, int l2, int m, bit a);
    int eff;
    eff = (l2 == 0 || l2 > 128) ? 128 : l2;
    add_exp(tcyc + 1, {1'b1, a, 2'b00, 16'(n), 6'd0});
    for (int s = 0; s < eff; s++) begin
      int t;
      t = (n - l1 + s + 65536) % 65536;
      for (int ch = 0; ch < NCH; ch++)
        if (hv(t, ch, m))
          add_exp(tcyc + 4 + 4 * s + ch, {1'b0, a, 2'(ch), 16'(t), hf(t, ch)});
    end
  endtask

  task automatic fire(int l1, int l2, output int tcyc, output int n);
    win_back = PG_AW'(l1);
    win_len  = 8'(l2);
    trig     = 1'b1;
    tcyc     = cyc;
    n        = tc_now;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic compare(string ctx);
    int lim;
    chk("R5", {ctx, " word count"}, cap_n, exp_n);
    lim = (cap_n < exp_n) ? cap_n : exp_n;
    for (int i = 0; i < lim; i++) begin
      if (exp_dat[i][W-1])
        chk("R1 R4", $sformatf("%s header", ctx), cap_dat[i], exp_dat[i]);
      else
        chk("R2 R3 R7", $sformatf("%s hit %0d", ctx, i), cap_dat[i], exp_dat[i]);
      chk("R6", $sformatf("%s clock of word %0d", ctx, i), cap_cyc[i], exp_cyc[i]);
      chk("R8", $sformatf("%s afull bit %0d", ctx, i), cap_dat[i][W-2], exp_dat[i][W-2]);
    end
    cap_n = 0;
    exp_n = 0;
  endtask

  initial begin
    int tc1, n1, tc2, n2, dc, dn;
    // R10: quiet during and after reset
    repeat (4) @(negedge clk);
    chk("R10", "push during reset", out_push, 0);
    rst = 1'b0;
    repeat (20) begin
      @(negedge clk);
      chk("R10", "push before trigger", out_push, 0);
    end

    // Table of windows
    for (int v = 0; v < NV; v++) begin
      int l1, l2, m;
      l1 = int'(VEC[v][18:11]);
      l2 = int'(VEC[v][10:3]);
      m  = int'(VEC[v][2:1]);
      mode = m;
      fifo_afull = VEC[v][0];
      repeat (140) @(negedge clk);
      cap_n = 0; exp_n = 0;
      fire(l1, l2, tc1, n1);
      add_window(tc1, n1, l1, l2, m, VEC[v][0]);
      repeat (4 * 128 + 12) @(negedge clk);
      compare($sformatf("R5 vector %0d", v));
    end

    // R9: retrigger mid-readout and at the last busy clock, then one later
    mode = 0; fifo_afull = 1'b0;
    repeat (140) @(negedge clk);
    cap_n = 0; exp_n = 0;
    fire(20, 2, tc1, n1);          // now in header clock h
    repeat (3) @(negedge clk);
    fire(5, 7, dc, dn);            // trigger in h+3, ignored
    repeat (5) @(negedge clk);
    fire(5, 7, dc, dn);            // trigger in h+9, ignored
    fire(3, 4, tc2, n2);           // trigger in h+10, accepted
    chk("R9", "accept clock offset", tc2 - tc1, 11);
    repeat (40) @(negedge clk);
    add_window(tc1, n1, 20, 2, 0, 1'b0);
    add_window(tc2, n2, 3, 4, 0, 1'b0);
    compare("R9 retrigger");

    // R1: window straddling the coarse time wrap
    mode = 2; fifo_afull = 1'b1;
    while (tc_now != 5) @(negedge clk);
    cap_n = 0; exp_n = 0;
    fire(10, 11, tc1, n1);
    chk("R1", "model coarse time at trigger", n1, 5);
    repeat (60) @(negedge clk);
    add_window(tc1, n1, 10, 11, 2, 1'b1);
    compare("R1 wrap");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule